// File: doc/BRIEF.md
# Fully Associative Range-Matched Translation Buffer

This block caches virtual-to-physical page translations in a small, fully associative array. Each entry holds its own page size, so 4 KiB, 2 MiB and 1 GiB pages sit side by side in the same array. An entry matches when the address falls inside the range that starts at the entry's start address and spans its page size. No fixed tag field is compared. The entries are kept in a recency order. A lookup resolves overlapping entries in favour of the most recently used one, and the insert path uses the same order to pick an entry to evict.

Callers use three request channels, each with a valid/ready pair. The maintenance channel flushes every entry, flushes only the non-global entries, or demaps the one entry that covers a given address. The insert channel writes a new translation. The lookup channel returns a registered response one cycle later: hit flag, physical address, global flag and page size. A lookup can also choose to promote the entry it hits to most recently used. Only one request is taken per cycle: maintenance first, then insert, then lookup.

Top module: `lru_tlb`

## Requirements
- R1: After reset no entry is valid, every response output is 0, and the first lookup misses.
- R2: Size code 0 selects 4 KiB, code 1 selects 2 MiB, code 2 selects 1 GiB, and code 3 behaves as 4 KiB. On insert, the address bits below the page size are cleared to form the start address. An entry hits when start <= address < start + page size.
- R3: On a hit, the physical address is the stored physical base ORed with the lookup address bits below the entry's page size.
- R4: A lookup that is accepted (valid and ready) gives rsp_valid_o = 1 on the following cycle, along with hit, address, global flag and size code. When the lookup misses, and in any cycle without a response, hit, address, global flag and size are all 0.
- R5: When several valid entries cover the address, the most recently used one supplies the result.
- R6: A hit with lkp_touch_i = 1 makes the hit entry the most recently used. With lkp_touch_i = 0 the recency order does not change.
- R7: An insert fills an invalid entry if one exists. Otherwise it evicts the least recently used entry. The inserted entry becomes the most recently used.
- R8: Maintenance op 0 (flush all) invalidates every entry.
- R9: Maintenance op 1 invalidates only the entries whose global flag is 0. The global entries stay valid and keep their relative recency order.
- R10: Maintenance op 2 (demap) invalidates only the most recently used entry that covers mnt_va_i, and leaves the recency order unchanged. With no covering entry it has no effect. Op 3 does nothing.
- R11: mnt_ready_o is always 1. ins_ready_o = !mnt_valid_i. lkp_ready_o = !mnt_valid_i && !ins_valid_i. A request that is not ready has no effect.
- R12: An insert does not check for an existing overlapping or identical entry, so duplicate entries can be present at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mnt_valid_i | input | 1 | Maintenance request |
| mnt_op_i | input | 2 | 0 flush all, 1 flush non-global, 2 demap, 3 no-op |
| mnt_va_i | input | VA_W | Demap address |
| mnt_ready_o | output | 1 | Maintenance accepted |
| ins_valid_i | input | 1 | Insert request |
| ins_va_i | input | VA_W | Virtual address inside the new page |
| ins_pa_i | input | PA_W | Physical base of the new page |
| ins_size_i | input | 2 | Page size code |
| ins_global_i | input | 1 | Global flag |
| ins_ready_o | output | 1 | Insert accepted |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_va_i | input | VA_W | Lookup address |
| lkp_touch_i | input | 1 | Promote the entry on a hit |
| lkp_ready_o | output | 1 | Lookup accepted |
| rsp_valid_o | output | 1 | Lookup response present |
| rsp_hit_o | output | 1 | Lookup hit |
| rsp_pa_o | output | PA_W | Translated physical address |
| rsp_global_o | output | 1 | Global flag of the hit entry |
| rsp_size_o | output | 2 | Size code of the hit entry |

## Verification
The bench aims at four cases. The first is overlapping pages, where a 4 KiB page inside a 1 GiB page must lose to the 1 GiB page once the larger page is touched. A design that picked by entry index instead of recency would return the wrong physical base here. The second is a lookup at the last byte of a page and at the first byte past it, which catches an off-by-one in the range compare or a wrong shift for a size code. The third is eviction after touches and after partial flushes. A design that reset or disturbed the recency order on a non-global flush or a demap would evict a different entry, and a later lookup would hit where a miss is expected. The fourth is requests that arrive together. A lookup or insert that leaks through alongside a maintenance request shows up as an extra response or as a changed entry.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_2M  = 2'd1,
    PG_1G  = 2'd2,
    PG_ALT = 2'd3
  } pg_size_e;

  typedef enum logic [1:0] {
    MNT_ALL   = 2'd0,
    MNT_LOCAL = 2'd1,
    MNT_DEMAP = 2'd2,
    MNT_NOP   = 2'd3
  } mnt_op_e;

  function automatic int unsigned pg_shift(logic [1:0] code);
    case (code)
      PG_2M:   return 21;
      PG_1G:   return 30;
      default: return 12;
    endcase
  endfunction

  function automatic logic [63:0] pg_mask(logic [1:0] code);
    return (64'd1 << pg_shift(code)) - 64'd1;
  endfunction
endpackage

// File: rtl/tlb_entry_match.sv
module tlb_entry_match
  import tlb_pkg::*;
#(
  parameter int VA_W = 40
) (
  input  logic            valid_i,
  input  logic [VA_W-1:0] start_i,
  input  logic [1:0]      size_i,
  input  logic [VA_W-1:0] va_i,
  output logic            hit_o
);
  localparam int EW = VA_W + 1;
  logic [EW-1:0] span, lim;

  always_comb begin
    span  = EW'(1) << pg_shift(size_i);
    lim   = {1'b0, start_i} + span;
    hit_o = valid_i && (start_i <= va_i) && ({1'b0, va_i} < lim);
  end
endmodule

// File: rtl/tlb_recency.sv
module tlb_recency #(
  parameter int N  = 8,
  parameter int AW = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 promote_i,
  input  logic [AW-1:0]        promote_idx_i,
  output logic [N-1:0][AW-1:0] age_o,
  output logic [AW-1:0]        lru_idx_o
);
  logic [N-1:0][AW-1:0] age_q;

  // age 0 is most recent; ages form a permutation of 0..N-1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) age_q[i] <= AW'(i);
    end else if (promote_i) begin
      for (int i = 0; i < N; i++) begin
        if (AW'(i) == promote_idx_i) age_q[i] <= '0;
        else if (age_q[i] < age_q[promote_idx_i]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    lru_idx_o = '0;
    for (int i = 0; i < N; i++)
      if (age_q[i] == AW'(N - 1)) lru_idx_o = AW'(i);
  end

  assign age_o = age_q;

  for (genvar a = 0; a < N; a++) begin : g_perm
    logic [N-1:0] holders;
    for (genvar e = 0; e < N; e++) begin : g_h
      assign holders[e] = (age_q[e] == AW'(a));
    end
    // R7
    age_perm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(holders) == 1);
  end
endmodule

// File: rtl/tlb_select.sv
module tlb_select #(
  parameter int N  = 8,
  parameter int AW = 3
) (
  input  logic [N-1:0]         match_i,
  input  logic [N-1:0]         vld_i,
  input  logic [N-1:0][AW-1:0] age_i,
  input  logic [AW-1:0]        lru_idx_i,
  output logic                 hit_o,
  output logic [AW-1:0]        hit_idx_o,
  output logic [AW-1:0]        fill_idx_o
);
  logic [AW-1:0] best_age, free_idx;
  logic          free_any;

  always_comb begin
    hit_o     = 1'b0;
    best_age  = '1;
    hit_idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (match_i[i] && (!hit_o || age_i[i] < best_age)) begin
        hit_o     = 1'b1;
        best_age  = age_i[i];
        hit_idx_o = AW'(i);
      end
    end
  end

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld_i[i]) begin
        free_any = 1'b1;
        free_idx = AW'(i);
      end
    end
    fill_idx_o = free_any ? free_idx : lru_idx_i;
  end
endmodule

// File: rtl/lru_tlb.sv
module lru_tlb
  import tlb_pkg::*;
#(
  parameter int N    = 8,
  parameter int VA_W = 40,
  parameter int PA_W = 40
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mnt_valid_i,
  input  logic [1:0]      mnt_op_i,
  input  logic [VA_W-1:0] mnt_va_i,
  output logic            mnt_ready_o,
  input  logic            ins_valid_i,
  input  logic [VA_W-1:0] ins_va_i,
  input  logic [PA_W-1:0] ins_pa_i,
  input  logic [1:0]      ins_size_i,
  input  logic            ins_global_i,
  output logic            ins_ready_o,
  input  logic            lkp_valid_i,
  input  logic [VA_W-1:0] lkp_va_i,
  input  logic            lkp_touch_i,
  output logic            lkp_ready_o,
  output logic            rsp_valid_o,
  output logic            rsp_hit_o,
  output logic [PA_W-1:0] rsp_pa_o,
  output logic            rsp_global_o,
  output logic [1:0]      rsp_size_o
);
  localparam int AW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]         vld_q, glb_q, match;
  logic [VA_W-1:0]      start_q [N];
  logic [PA_W-1:0]      pa_q    [N];
  logic [1:0]           sz_q    [N];
  logic [N-1:0][AW-1:0] age;
  logic [AW-1:0]        lru_idx, hit_idx, fill_idx, prom_idx;
  logic                 hit, do_mnt, do_ins, do_lkp, promote;
  logic [VA_W-1:0]      cmp_va;
  mnt_op_e              op;

  assign mnt_ready_o = 1'b1;
  assign ins_ready_o = !mnt_valid_i;
  assign lkp_ready_o = !mnt_valid_i && !ins_valid_i;
  assign do_mnt      = mnt_valid_i;
  assign do_ins      = ins_valid_i && ins_ready_o;
  assign do_lkp      = lkp_valid_i && lkp_ready_o;
  assign op          = mnt_op_e'(mnt_op_i);
  // demap and lookup share the matchers; maintenance owns them when present
  assign cmp_va      = mnt_valid_i ? mnt_va_i : lkp_va_i;

  for (genvar g = 0; g < N; g++) begin : g_match
    tlb_entry_match #(.VA_W(VA_W)) i_match (
      .valid_i(vld_q[g]), .start_i(start_q[g]), .size_i(sz_q[g]),
      .va_i(cmp_va), .hit_o(match[g])
    );
  end

  tlb_select #(.N(N), .AW(AW)) i_select (
    .match_i(match), .vld_i(vld_q), .age_i(age), .lru_idx_i(lru_idx),
    .hit_o(hit), .hit_idx_o(hit_idx), .fill_idx_o(fill_idx)
  );

  assign promote  = do_ins || (do_lkp && hit && lkp_touch_i);
  assign prom_idx = do_ins ? fill_idx : hit_idx;

  tlb_recency #(.N(N), .AW(AW)) i_recency (
    .clk_i(clk_i), .rst_ni(rst_ni), .promote_i(promote),
    .promote_idx_i(prom_idx), .age_o(age), .lru_idx_o(lru_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      glb_q <= '0;
      for (int i = 0; i < N; i++) begin
        start_q[i] <= '0;
        pa_q[i]    <= '0;
        sz_q[i]    <= '0;
      end
    end else if (do_mnt) begin
      case (op)
        MNT_ALL:   vld_q <= '0;
        MNT_LOCAL: vld_q <= vld_q & glb_q;
        MNT_DEMAP: if (hit) vld_q[hit_idx] <= 1'b0;
        default:   ;
      endcase
    end else if (do_ins) begin
      vld_q[fill_idx]   <= 1'b1;
      glb_q[fill_idx]   <= ins_global_i;
      start_q[fill_idx] <= ins_va_i & ~VA_W'(pg_mask(ins_size_i));
      pa_q[fill_idx]    <= ins_pa_i;
      sz_q[fill_idx]    <= ins_size_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_hit_o    <= 1'b0;
      rsp_pa_o     <= '0;
      rsp_global_o <= 1'b0;
      rsp_size_o   <= '0;
    end else begin
      rsp_valid_o  <= do_lkp;
      rsp_hit_o    <= do_lkp && hit;
      rsp_pa_o     <= (do_lkp && hit)
                      ? (pa_q[hit_idx] | PA_W'(lkp_va_i & VA_W'(pg_mask(sz_q[hit_idx]))))
                      : '0;
      rsp_global_o <= do_lkp && hit && glb_q[hit_idx];
      rsp_size_o   <= (do_lkp && hit) ? sz_q[hit_idx] : 2'd0;
    end
  end

  // R4
  rsp_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_valid_i && lkp_ready_o) |=> rsp_valid_o);
  // R4
  rsp_hit_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit_o |-> rsp_valid_o);
  // R8
  flush_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mnt_valid_i && mnt_op_i == 2'd0) |=> (vld_q == '0));
  // R9
  flush_local_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mnt_valid_i && mnt_op_i == 2'd1) |=> ((vld_q & ~glb_q) == '0));
  // R10
  demap_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mnt_valid_i && mnt_op_i == 2'd2 && hit)
      |=> ($countones(vld_q) == $past($countones(vld_q)) - 1));
  // R7
  ins_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_valid_i && ins_ready_o) |=> vld_q[$past(fill_idx)]);
endmodule

// File: tb/test_lru_tlb.sv
module test_lru_tlb;
  localparam int N = 8;
  localparam int VA_W = 40;
  localparam int PA_W = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mv = 0, iv = 0, ig = 0, lv = 0, lt = 0;
  logic [1:0] mop = 0, isz = 0;
  logic [VA_W-1:0] mva = 0, iva = 0, lva = 0;
  logic [PA_W-1:0] ipa = 0;
  logic m_rdy, i_rdy, l_rdy, r_v, r_h, r_g;
  logic [PA_W-1:0] r_pa;
  logic [1:0] r_sz;

  always #4 clk = ~clk;

  lru_tlb #(.N(N), .VA_W(VA_W), .PA_W(PA_W)) i_lru_tlb (
    .clk_i(clk), .rst_ni(rst_n),
    .mnt_valid_i(mv), .mnt_op_i(mop), .mnt_va_i(mva), .mnt_ready_o(m_rdy),
    .ins_valid_i(iv), .ins_va_i(iva), .ins_pa_i(ipa), .ins_size_i(isz),
    .ins_global_i(ig), .ins_ready_o(i_rdy),
    .lkp_valid_i(lv), .lkp_va_i(lva), .lkp_touch_i(lt), .lkp_ready_o(l_rdy),
    .rsp_valid_o(r_v), .rsp_hit_o(r_h), .rsp_pa_o(r_pa),
    .rsp_global_o(r_g), .rsp_size_o(r_sz)
  );

  typedef struct {
    longint unsigned st;
    longint unsigned pa;
    int              sh;
    logic [1:0]      sz;
    bit              g;
  } ment_t;

  ment_t mq[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string cur = "R1";

  task automatic chk(string what, longint unsigned act, longint unsigned exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", cur, what, act, exp, $time);
    end
  endtask

  function automatic int shift_of(logic [1:0] s);
    if (s == 2'd1) return 21;
    if (s == 2'd2) return 30;
    return 12;
  endfunction

  function automatic int find(longint unsigned va);
    for (int i = 0; i < mq.size(); i++)
      if (mq[i].st <= va && va < mq[i].st + (64'd1 << mq[i].sh)) return i;
    return -1;
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // one request cycle; starts and ends at a falling edge
  task automatic step(bit a_mv, logic [1:0] a_mop, logic [39:0] a_mva,
                      bit a_iv, logic [39:0] a_iva, logic [39:0] a_ipa,
                      logic [1:0] a_isz, bit a_ig,
                      bit a_lv, logic [39:0] a_lva, bit a_lt);
    bit e_v, e_h, e_g;
    longint unsigned e_pa;
    logic [1:0] e_sz;
    int k;
    mv = a_mv; mop = a_mop; mva = a_mva;
    iv = a_iv; iva = a_iva; ipa = a_ipa; isz = a_isz; ig = a_ig;
    lv = a_lv; lva = a_lva; lt = a_lt;
    #1;
    chk("mnt_ready", m_rdy, 1);
    chk("ins_ready", i_rdy, !a_mv);
    chk("lkp_ready", l_rdy, !a_mv && !a_iv);
    e_v = 0; e_h = 0; e_g = 0; e_pa = 0; e_sz = 0;
    if (a_mv) begin
      if (a_mop == 2'd0) mq.delete();
      else if (a_mop == 2'd1) begin
        ment_t keep[$];
        foreach (mq[i]) if (mq[i].g) keep.push_back(mq[i]);
        mq = keep;
      end else if (a_mop == 2'd2) begin
        k = find(a_mva);
        if (k >= 0) mq.delete(k);
      end
    end else if (a_iv) begin
      ment_t e;
      e.sh = shift_of(a_isz);
      e.st = a_iva & ~((64'd1 << e.sh) - 1);
      e.pa = a_ipa;
      e.sz = a_isz;
      e.g  = a_ig;
      if (mq.size() == N) void'(mq.pop_back());
      mq.push_front(e);
    end else if (a_lv) begin
      e_v = 1;
      k = find(a_lva);
      if (k >= 0) begin
        ment_t t;
        t = mq[k];
        e_h = 1;
        e_g = t.g;
        e_sz = t.sz;
        e_pa = (t.pa | (a_lva & ((64'd1 << t.sh) - 1))) & ((64'd1 << PA_W) - 1);
        if (a_lt) begin
          mq.delete(k);
          mq.push_front(t);
        end
      end
    end
    @(posedge clk);
    #2;
    chk("rsp_valid", r_v, e_v);
    chk("rsp_hit", r_h, e_h);
    chk("rsp_pa", r_pa, e_pa);
    chk("rsp_global", r_g, e_g);
    chk("rsp_size", r_sz, e_sz);
    @(negedge clk);
  endtask

  task automatic look(logic [39:0] va, bit t);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, va, t);
  endtask
  task automatic put(logic [39:0] va, logic [39:0] pa, logic [1:0] sz, bit g);
    step(0, 0, 0, 1, va, pa, sz, g, 0, 0, 0);
  endtask
  task automatic maint(logic [1:0] op, logic [39:0] va);
    step(1, op, va, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  function automatic logic [39:0] rnd_va();
    return 40'(($urandom % 4) * 64'h4000_0000 + ($urandom % 8) * 64'h20_0000 +
               ($urandom % 8) * 64'h1000 + ($urandom % 64'h1000));
  endfunction

  initial begin
    #(8 * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    #10;
    cur = "R1";
    chk("rsp_valid", r_v, 0);
    chk("rsp_hit", r_h, 0);
    chk("rsp_pa", r_pa, 0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    look(40'h1234_5678, 1);

    cur = "R2";
    put(40'h12_3456_7abc, 40'hAB_0000_0000, 2'd0, 0);
    look(40'h12_3456_7000, 0);
    look(40'h12_3456_7fff, 0);
    look(40'h12_3456_8000, 0);
    look(40'h12_3456_6fff, 0);
    put(40'h05_0012_3456, 40'h01_0000_0000, 2'd1, 0);
    look(40'h05_001f_ffff, 0);
    look(40'h05_0020_0000, 0);
    put(40'h70_0000_1234, 40'h02_0000_0000, 2'd3, 1);
    look(40'h70_0000_0fff, 0);
    look(40'h70_0000_1000, 0);

    cur = "R3";
    put(40'h00_8000_0000, 40'h30_0000_0000, 2'd2, 1);
    look(40'h00_bfff_fffc, 1);

    cur = "R5";
    maint(2'd0, 0);
    put(40'h0, 40'h40_0000_0000, 2'd2, 0);
    put(40'h5000, 40'h77_0000_0000, 2'd0, 1);
    look(40'h5008, 0);

    cur = "R6";
    look(40'h9000, 0);
    look(40'h5008, 0);
    look(40'h9000, 1);
    look(40'h5008, 0);

    cur = "R10";
    maint(2'd2, 40'h6000);
    look(40'h5008, 0);
    maint(2'd2, 40'h5008);
    look(40'h5008, 0);
    maint(2'd3, 40'h0);
    look(40'h0, 0);

    cur = "R8";
    maint(2'd0, 0);
    look(40'h0, 0);

    cur = "R7";
    for (int i = 0; i < 9; i++) put(40'(i) << 12, 40'h10_0000_0000 + (40'(i) << 20), 2'd0, 0);
    look(40'h0, 0);
    look(40'h1000, 1);
    put(40'h20_0000, 40'h5, 2'd0, 0);
    look(40'h1000, 0);
    look(40'h2000, 0);

    cur = "R9";
    maint(2'd0, 0);
    put(40'h1000, 40'h1_0000_0000, 2'd0, 1);
    put(40'h2000, 40'h2_0000_0000, 2'd0, 0);
    put(40'h3000, 40'h3_0000_0000, 2'd0, 1);
    maint(2'd1, 0);
    look(40'h1000, 0);
    look(40'h2000, 0);
    look(40'h3000, 0);
    for (int i = 0; i < 7; i++) put(40'h10_0000 + (40'(i) << 12), 40'h9, 2'd0, 0);
    look(40'h1000, 0);
    look(40'h3000, 0);

    cur = "R11";
    step(1, 2'd3, 0, 1, 40'h4000, 40'h4, 2'd0, 0, 1, 40'h3000, 1);
    step(0, 2'd0, 0, 1, 40'h4000, 40'h4, 2'd0, 0, 1, 40'h3000, 1);
    step(1, 2'd0, 0, 0, 0, 0, 0, 0, 1, 40'h4000, 0);
    look(40'h4000, 0);

    cur = "R12";
    put(40'h8000, 40'hA_0000_0000, 2'd0, 0);
    put(40'h8000, 40'hB_0000_0000, 2'd0, 1);
    look(40'h8010, 0);
    maint(2'd2, 40'h8000);
    look(40'h8010, 0);

    cur = "R4";
    for (int c = 0; c < 4000; c++) begin
      int r;
      bit a_mv, a_iv, a_lv;
      logic [1:0] a_op;
      r = $urandom % 100;
      a_mv = (r < 6);
      a_iv = ($urandom % 100) < 30;
      a_lv = ($urandom % 100) < 75;
      r = $urandom % 20;
      a_op = (r < 2) ? 2'd0 : (r < 7) ? 2'd1 : (r < 17) ? 2'd2 : 2'd3;
      step(a_mv, a_op, rnd_va(), a_iv, rnd_va(),
           40'({$urandom, $urandom}), 2'($urandom % 3), 1'($urandom),
           a_lv, rnd_va(), 1'($urandom));
    end

    summary();
  end
endmodule